// File: doc/BRIEF.md
# Banked Flash Address Mapper

This block turns a 16-bit CPU address into a 17-bit physical flash address for a processor whose program needs more flash than its address space can reach at once. The lower 32 KB of CPU space is a fixed common region that maps straight through to the first 32 KB of flash. The next 16 KB of CPU space is a window onto one of six 16 KB flash banks. The banks sit back to back in flash, directly after the common region. CPU addresses above the window are not flash.

A one-byte bank select register sits at CPU address FFF3H and picks the bank that the window shows. The CPU writes and reads it over a plain byte port. The block also guards the banking rules. It refuses a bank change made while the CPU runs code from the window. It refuses a bank code that does not exist. It flags an instruction fetch that runs from the common region into the window while a bank other than 0 is selected. Each such event raises a violation flag for one cycle.

All pins are plain control and address signals, with no valid/ready flow. Translation is combinational, from the address input and the registered bank value.

Top module: `bank_flash_mapper`

## Requirements
- R1: After reset the bank register holds 0. A read at FFF3H returns 00H and `viol` is low.
- R2: A write (`reg_wr`=1, `reg_addr`=FFF3H, `cur_pc` below 8000H or at C000H and above) of a code from 0 to 5 in `reg_wdata[2:0]` loads that bank at the next rising edge. Later reads at FFF3H return it in bits 2:0. A write to any other address leaves the bank unchanged.
- R3: Readback bits 7:3 are always 0, whatever was written to them. `reg_rdata` is 00H when `reg_addr` is not FFF3H.
- R4: A write of code 6 or 7 leaves the bank unchanged and raises `viol` for one cycle.
- R5: For CPU addresses 0000H to 7FFFH, `phys_addr` equals the CPU address and `flash_hit` is 1, whatever the bank.
- R6: For CPU addresses 8000H to BFFFH, `phys_addr` = 08000H + bank×4000H + (address − 8000H) and `flash_hit` is 1. Bank 5 therefore spans 1C000H to 1FFFFH.
- R7: A write to FFF3H while `cur_pc` lies in 8000H to BFFFH leaves the bank unchanged and raises `viol` for one cycle.
- R8: A fetch (`acc_fetch`=1) whose bytes `acc_addr` .. `acc_addr`+`acc_len`−1 include both 7FFFH and 8000H raises `viol` when the bank is not 0. The same fetch with bank 0 selected raises nothing, and neither does a fetch that ends at or before 7FFFH.
- R9: For CPU addresses C000H and above, `flash_hit` is 0 and `phys_addr` is 0.
- R10: `viol` is registered. It is high exactly in the cycle after an offending edge and low in every cycle that follows no offence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | CPU address of the data access |
| reg_wr | input | 1 | Byte write strobe for the data access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational; bank code at FFF3H, else 0 |
| cur_pc | input | 16 | Address of the instruction issuing the data access |
| acc_addr | input | 16 | Fetch or read address to translate |
| acc_fetch | input | 1 | The access on `acc_addr` is an instruction fetch |
| acc_len | input | 3 | Fetch length in bytes (0 means no span) |
| phys_addr | output | 17 | Physical flash address |
| flash_hit | output | 1 | `acc_addr` falls in flash |
| viol | output | 1 | One-cycle flag for a banking rule violation |

## Verification
Assertions check these rules on every cycle:
- The bank register never holds a code of 6 or higher.
- A refused write (a bad code, or a write from inside the window) leaves the bank unchanged and raises the flag on the following cycle.
- An accepted write lands the new code.
- Common and out-of-range addresses translate as required.
- The flag never rises without a cause in the cycle before.

Only the bench's scenarios can show the full translation arithmetic across all six banks at the window edges. They also show the exact readback values, and that a boundary-straddling fetch is tolerated under bank 0 but flagged under the others.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int CPU_AW    = 16;
  localparam int PHYS_AW   = 17;
  localparam int DATA_W    = 8;
  localparam int SEL_W     = 3;
  localparam int NUM_BANKS = 6;
  localparam int COMMON_AW = 15;
  localparam int WIN_AW    = 14;
  localparam int LEN_W     = 3;
  localparam logic [CPU_AW-1:0] SEL_ADDR = 16'hFFF3;
endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 3,
  parameter int NUM_BANKS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              wr_blocked,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  bank,
  output logic              bad_code,
  output logic              win_write
);
  localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_BANKS - 1);

  logic [SEL_W-1:0] code;
  logic             code_ok;
  logic             accept;

  assign code      = wdata[SEL_W-1:0];
  assign code_ok   = (code <= LAST_CODE);
  assign accept    = wr_hit && !wr_blocked && code_ok;
  assign bad_code  = wr_hit && !code_ok;
  assign win_write = wr_hit && wr_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n)      bank <= '0;
    else if (accept) bank <= code;
  end

  // R4
  bank_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank <= LAST_CODE);
  // R4
  bad_code_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> $stable(bank));
  // R7
  win_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_write |=> $stable(bank));
  // R2
  accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_blocked && wdata[SEL_W-1:0] < SEL_W'(NUM_BANKS))
      |=> bank == $past(wdata[SEL_W-1:0]));
endmodule

// File: rtl/bank_addr_xlat.sv
module bank_addr_xlat #(
  parameter int CPU_AW    = 16,
  parameter int PHYS_AW   = 17,
  parameter int SEL_W     = 3,
  parameter int NUM_BANKS = 6,
  parameter int COMMON_AW = 15,
  parameter int WIN_AW    = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   bank,
  input  logic [CPU_AW-1:0]  addr,
  output logic [PHYS_AW-1:0] phys,
  output logic               hit
);
  typedef logic [CPU_AW:0] ext_t;
  localparam ext_t COMMON_LIM = ext_t'(1 << COMMON_AW);
  localparam ext_t WIN_LIM    = ext_t'((1 << COMMON_AW) + (1 << WIN_AW));

  logic [PHYS_AW-1:0] base_tbl [NUM_BANKS];
  logic [PHYS_AW-1:0] base_sel;
  logic               in_common;
  logic               in_win;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_base
    assign base_tbl[g] = PHYS_AW'((1 << COMMON_AW) + g * (1 << WIN_AW));
  end

  always_comb begin
    base_sel = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank == SEL_W'(i)) base_sel = base_tbl[i];
  end

  assign in_common = ext_t'(addr) < COMMON_LIM;
  assign in_win    = !in_common && (ext_t'(addr) < WIN_LIM);

  always_comb begin
    phys = '0;
    if (in_common)   phys = PHYS_AW'(addr);
    else if (in_win) phys = base_sel + PHYS_AW'(addr[WIN_AW-1:0]);
  end
  assign hit = in_common || in_win;

  // R5
  common_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[CPU_AW-1] == 1'b0) |-> (hit && phys[CPU_AW-1:0] == addr && phys[PHYS_AW-1:CPU_AW] == '0));
  // R9
  above_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[CPU_AW-1:CPU_AW-2] == 2'b11) |-> (!hit && phys == '0));
  // R6
  window_above_common_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[CPU_AW-1:CPU_AW-2] == 2'b10) |-> (hit && phys >= PHYS_AW'(1 << COMMON_AW)));
endmodule

// File: rtl/bank_guard.sv
module bank_guard #(
  parameter int CPU_AW    = 16,
  parameter int SEL_W     = 3,
  parameter int COMMON_AW = 15,
  parameter int LEN_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bank,
  input  logic              acc_fetch,
  input  logic [CPU_AW-1:0] acc_addr,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic              bad_code,
  input  logic              win_write,
  output logic              viol
);
  typedef logic [CPU_AW:0] ext_t;
  localparam ext_t COMMON_LIM = ext_t'(1 << COMMON_AW);

  ext_t last_byte;
  logic crosses;
  logic straddle_bad;
  logic cause;

  assign last_byte    = ext_t'(acc_addr) + ext_t'(acc_len) - ext_t'(1);
  assign crosses      = acc_fetch && (acc_len != '0)
                        && (ext_t'(acc_addr) < COMMON_LIM) && (last_byte >= COMMON_LIM);
  assign straddle_bad = crosses && (bank != '0);
  assign cause        = bad_code || win_write || straddle_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= cause;
  end

  // R10
  viol_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(bad_code || win_write || (acc_fetch && bank != '0)));
  // R4
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> viol);
  // R7
  win_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_write |=> viol);
endmodule

// File: rtl/bank_flash_mapper.sv
module bank_flash_mapper
  import bankmap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [CPU_AW-1:0]   cur_pc,
  input  logic [CPU_AW-1:0]   acc_addr,
  input  logic                acc_fetch,
  input  logic [LEN_W-1:0]    acc_len,
  output logic [PHYS_AW-1:0]  phys_addr,
  output logic                flash_hit,
  output logic                viol
);
  logic             sel_hit;
  logic             wr_hit;
  logic             pc_in_win;
  logic [SEL_W-1:0] bank;
  logic             bad_code;
  logic             win_write;

  assign sel_hit   = (reg_addr == SEL_ADDR);
  assign wr_hit    = reg_wr && sel_hit;
  assign pc_in_win = (cur_pc[CPU_AW-1:CPU_AW-2] == 2'b10);
  assign reg_rdata = sel_hit ? {{(DATA_W-SEL_W){1'b0}}, bank} : '0;

  bank_select_reg #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_BANKS(NUM_BANKS)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_blocked(pc_in_win),
    .wdata(reg_wdata), .bank(bank), .bad_code(bad_code), .win_write(win_write)
  );

  bank_addr_xlat #(
    .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW), .SEL_W(SEL_W), .NUM_BANKS(NUM_BANKS),
    .COMMON_AW(COMMON_AW), .WIN_AW(WIN_AW)
  ) u_xlat (
    .clk(clk), .rst_n(rst_n), .bank(bank), .addr(acc_addr),
    .phys(phys_addr), .hit(flash_hit)
  );

  bank_guard #(
    .CPU_AW(CPU_AW), .SEL_W(SEL_W), .COMMON_AW(COMMON_AW), .LEN_W(LEN_W)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .bank(bank), .acc_fetch(acc_fetch),
    .acc_addr(acc_addr), .acc_len(acc_len), .bad_code(bad_code),
    .win_write(win_write), .viol(viol)
  );

  // R3
  other_addr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |-> reg_rdata == '0);
endmodule

// File: tb/bank_flash_mapper_bench.sv
module bank_flash_mapper_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] cur_pc = 16'h0100;
  logic [15:0] acc_addr = '0;
  logic        acc_fetch = 1'b0;
  logic [2:0]  acc_len = '0;
  logic [16:0] phys_addr;
  logic        flash_hit;
  logic        viol;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_flash_mapper u_bank_flash_mapper (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_pc(cur_pc),
    .acc_addr(acc_addr), .acc_fetch(acc_fetch), .acc_len(acc_len),
    .phys_addr(phys_addr), .flash_hit(flash_hit), .viol(viol)
  );

  // {bank code, cpu address, expected physical, expected hit}
  localparam logic [36:0] VECS [0:14] = '{
    {3'd0, 16'h0000, 17'h00000, 1'b1},
    {3'd0, 16'h7FFF, 17'h07FFF, 1'b1},
    {3'd0, 16'h8000, 17'h08000, 1'b1},
    {3'd0, 16'hBFFF, 17'h0BFFF, 1'b1},
    {3'd0, 16'hC000, 17'h00000, 1'b0},
    {3'd1, 16'h8000, 17'h0C000, 1'b1},
    {3'd1, 16'hBFFF, 17'h0FFFF, 1'b1},
    {3'd2, 16'h8123, 17'h10123, 1'b1},
    {3'd3, 16'hA000, 17'h16000, 1'b1},
    {3'd4, 16'h8000, 17'h18000, 1'b1},
    {3'd5, 16'h8000, 17'h1C000, 1'b1},
    {3'd5, 16'hBFFF, 17'h1FFFF, 1'b1},
    {3'd5, 16'h7FFF, 17'h07FFF, 1'b1},
    {3'd5, 16'hFFF3, 17'h00000, 1'b0},
    {3'd2, 16'h0000, 17'h00000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write cycle; returns viol sampled in the cycle after the edge
  task automatic do_write(input logic [15:0] addr, input logic [7:0] d,
                          input logic [15:0] pc, output logic v);
    @(negedge clk);
    reg_addr = addr; reg_wdata = d; cur_pc = pc; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; cur_pc = 16'h0100;
    v = viol;
    reg_addr = 16'hFFF3;
    #1;
  endtask

  task automatic fetch_once(input logic [15:0] a, input logic [2:0] len, output logic v);
    @(negedge clk);
    acc_addr = a; acc_len = len; acc_fetch = 1'b1;
    @(negedge clk);
    acc_fetch = 1'b0; acc_len = '0;
    v = viol;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_addr = 16'hFFF3;
    @(negedge clk); #1;
    check("R1 reset readback", 32'(reg_rdata), 32'h00);
    check("R1 reset viol", 32'(viol), 32'h0);

    // vector table walk
    for (int i = 0; i < 15; i++) begin
      do_write(16'hFFF3, {5'b0, VECS[i][36:34]}, 16'h0100, v);
      check("R2 readback of bank", 32'(reg_rdata), 32'(VECS[i][36:34]));
      acc_addr = VECS[i][33:18];
      #1;
      check("R5/R6/R9 phys_addr", 32'(phys_addr), 32'(VECS[i][17:1]));
      check("R5/R6/R9 flash_hit", 32'(flash_hit), 32'(VECS[i][0]));
    end

    // R3: upper bits written are dropped; other address reads zero
    do_write(16'hFFF3, 8'hFC, 16'h0100, v);
    check("R3 upper bits read zero", 32'(reg_rdata), 32'h04);
    check("R10 no viol on legal write", 32'(v), 32'h0);
    reg_addr = 16'h1234; #1;
    check("R3 other address reads zero", 32'(reg_rdata), 32'h00);

    // R2: write to a different address is ignored
    do_write(16'hFFF2, 8'h01, 16'h0100, v);
    check("R2 write elsewhere ignored", 32'(reg_rdata), 32'h04);

    // R4: prohibited codes
    do_write(16'hFFF3, 8'h06, 16'h0100, v);
    check("R4 code 6 viol", 32'(v), 32'h1);
    check("R4 code 6 ignored", 32'(reg_rdata), 32'h04);
    @(negedge clk); #1;
    check("R10 viol one cycle", 32'(viol), 32'h0);
    do_write(16'hFFF3, 8'h07, 16'h0100, v);
    check("R4 code 7 viol", 32'(v), 32'h1);
    check("R4 code 7 ignored", 32'(reg_rdata), 32'h04);

    // R7: write from inside the window
    do_write(16'hFFF3, 8'h01, 16'h9000, v);
    check("R7 window write viol", 32'(v), 32'h1);
    check("R7 window write ignored", 32'(reg_rdata), 32'h04);
    do_write(16'hFFF3, 8'h01, 16'hBFFF, v);
    check("R7 window top edge viol", 32'(v), 32'h1);
    check("R7 window top edge ignored", 32'(reg_rdata), 32'h04);
    do_write(16'hFFF3, 8'h02, 16'hC000, v);
    check("R2 write from above window allowed", 32'(reg_rdata), 32'h02);
    check("R10 no viol from above window", 32'(v), 32'h0);

    // R8: straddling fetch
    fetch_once(16'h7FFE, 3'd3, v);
    check("R8 straddle bank 2 viol", 32'(v), 32'h1);
    @(negedge clk); #1;
    check("R10 straddle viol clears", 32'(viol), 32'h0);
    fetch_once(16'h7FFC, 3'd4, v);
    check("R8 ends at 7FFF no viol", 32'(v), 32'h0);
    do_write(16'hFFF3, 8'h00, 16'h0100, v);
    fetch_once(16'h7FFF, 3'd2, v);
    check("R8 straddle bank 0 no viol", 32'(v), 32'h0);

    // R1: reset again after a bank change
    do_write(16'hFFF3, 8'h05, 16'h0100, v);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 reset clears bank", 32'(reg_rdata), 32'h00);
    acc_addr = 16'h8000; #1;
    check("R1 reset maps bank 0", 32'(phys_addr), 32'h08000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule